// File: doc/BRIEF.md
# AC97 Codec Register File

This block stands in for the control side of a primary AC97 codec. It holds the codec's bank of 16-bit registers behind a single 32-bit command word. A host presents a command on a valid/ready port. The command carries a codec select, a read/write flag, a 7-bit register byte address and 16 bits of write data. The block accepts the command in one cycle. One cycle later it exposes a response word.

Writes are not plain stores. The main and PCM output volume registers are saturated and masked. The two sample-rate registers are held at 48000 unless variable-rate operation is enabled, and when it is enabled they snap to the nearest supported rate. Identification registers ignore writes, and the power-down register keeps its status byte. Any write to address 0x00 restores every register to its power-on value.

From the main and PCM output volume registers, the block continuously derives one 8-bit playback level per channel and a combined mute flag. Downstream audio logic can consume these directly.

Top module: `ac97_codec_regs`

## Requirements
- R1: A command whose select field (bits 31:30) is nonzero is dropped entirely: no register changes and the response word keeps its previous value.
- R2: A read (bit 23 = 1) with select 0 sets the response word one cycle later to the request's bits 31:30 and 23:16, the register contents in bits 15:0, and bit 25 = 1 as data valid.
- R3: A write (bit 23 = 0) with select 0 sets the response word one cycle later to the request masked with 0xC0FFFFFF.
- R4: After reset, or any write to address 0x00, the registers hold these values, with every other register at 0:
  - 0x00 = 0x6A90
  - 0x02, 0x04, 0x06 and 0x1C = 0x8000
  - 0x0C and 0x0E = 0x8008
  - 0x10, 0x12, 0x14, 0x16 and 0x18 = 0x8808
  - 0x26 = 0x000F
  - 0x28 = 0x0A05
  - 0x2A = 0x0400
  - 0x2C and 0x32 = 48000
- R5: A write to main volume (0x02) first sets bits 12:8 to ones if data bit 13 is set, and bits 4:0 to ones if data bit 5 is set. Writes to 0x02 and to PCM volume (0x18) store the data ANDed with 0x9F1F.
- R6: In extended control (0x2A), only bit 0 (variable-rate enable) is writable. Writing it as 0 also sets 0x2C and 0x32 to 48000.
- R7: Writes to 0x2C or 0x32 are ignored while 0x2A bit 0 is 0. While it is 1, the stored value is the first rate in 8000, 11025, 16000, 22050, 32000, 44100 that the data lies below the midpoint to the next rate of. Data of 46050 or above stores 48000.
- R8: A write to power-down (0x26) updates bits 15:8 only; bits 7:0 keep their value.
- R9: Writes to 0x28, 0x7C and 0x7E have no effect.
- R10: Writes to any other address store the data unchanged in entry address/2.
- R11: With m and p the 5-bit main and PCM fields of a channel (bits 12:8 left, bits 4:0 right), and s(x) = floor(255·x/31), the channel level is floor((255−s(m))·(255−s(p))/255). `mute` is the OR of bit 15 of 0x02 and 0x18.
- R12: `cmd_ready` is 0 in reset and 1 otherwise. A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high; `cmd_data` is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_data | input | 32 | Command word |
| cmd_word | output | 32 | Response / command register |
| gain_left | output | 8 | Combined left playback level |
| gain_right | output | 8 | Combined right playback level |
| mute | output | 1 | Combined mute |

## Verification
The bench drives each rate-snapping midpoint from both sides (9511/9512, 46049/46050) and a value inside the table. A design with an off-by-one threshold would store the neighbouring rate. It writes rate registers while variable rate is off and clears the enable after rates were changed; a block that skipped the lock or the restore would read back the written or stale rate. It issues commands with a nonzero codec select and checks that both the response and the main volume are untouched; it also presents data with `cmd_valid` low and checks that it was not taken. It compares the derived levels against the formula for asymmetric fields, where swapped channels or a missing scale step show as wrong levels.

// File: rtl/ac97_regs_pkg.sv
package ac97_regs_pkg;

  localparam int CMD_W  = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int GAIN_W = 8;

  typedef struct packed {
    logic [1:0]        sel;
    logic [5:0]        rsv;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ac_cmd_t;

  // byte addresses whose write behaviour or reset value is special
  localparam logic [ADDR_W-1:0] REG_SOFTRST  = 7'h00;
  localparam logic [ADDR_W-1:0] REG_MAIN_VOL = 7'h02;
  localparam logic [ADDR_W-1:0] REG_HP_VOL   = 7'h04;
  localparam logic [ADDR_W-1:0] REG_MONO_VOL = 7'h06;
  localparam logic [ADDR_W-1:0] REG_PHONE    = 7'h0C;
  localparam logic [ADDR_W-1:0] REG_MIC      = 7'h0E;
  localparam logic [ADDR_W-1:0] REG_LINE     = 7'h10;
  localparam logic [ADDR_W-1:0] REG_CDIN     = 7'h12;
  localparam logic [ADDR_W-1:0] REG_VIDEO    = 7'h14;
  localparam logic [ADDR_W-1:0] REG_AUXIN    = 7'h16;
  localparam logic [ADDR_W-1:0] REG_PCM_VOL  = 7'h18;
  localparam logic [ADDR_W-1:0] REG_REC_GAIN = 7'h1C;
  localparam logic [ADDR_W-1:0] REG_PWR      = 7'h26;
  localparam logic [ADDR_W-1:0] REG_XID      = 7'h28;
  localparam logic [ADDR_W-1:0] REG_XCTL     = 7'h2A;
  localparam logic [ADDR_W-1:0] REG_DAC_RATE = 7'h2C;
  localparam logic [ADDR_W-1:0] REG_ADC_RATE = 7'h32;
  localparam logic [ADDR_W-1:0] REG_ID_HI    = 7'h7C;
  localparam logic [ADDR_W-1:0] REG_ID_LO    = 7'h7E;

  localparam logic [DATA_W-1:0] VOL_KEEP  = 16'h9F1F;
  localparam logic [DATA_W-1:0] RATE_MAX  = 16'd48000;
  localparam int                NUM_RATES = 7;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:1];
  endfunction

  function automatic logic [DATA_W-1:0] reset_value(input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] a;
    a = {idx, 1'b0};
    case (a)
      REG_SOFTRST:                                       return 16'h6A90;
      REG_MAIN_VOL, REG_HP_VOL, REG_MONO_VOL,
      REG_REC_GAIN:                                      return 16'h8000;
      REG_PHONE, REG_MIC:                                return 16'h8008;
      REG_LINE, REG_CDIN, REG_VIDEO, REG_AUXIN,
      REG_PCM_VOL:                                       return 16'h8808;
      REG_PWR:                                           return 16'h000F;
      REG_XID:                                           return 16'h0A05;
      REG_XCTL:                                          return 16'h0400;
      REG_DAC_RATE, REG_ADC_RATE:                        return RATE_MAX;
      default:                                           return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rate_at(input int i);
    case (i)
      0:       return 16'd8000;
      1:       return 16'd11025;
      2:       return 16'd16000;
      3:       return 16'd22050;
      4:       return 16'd32000;
      5:       return 16'd44100;
      default: return RATE_MAX;
    endcase
  endfunction

  // first rate whose midpoint to its successor lies above v
  function automatic logic [DATA_W-1:0] snap_rate(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    logic              hit;
    r   = RATE_MAX;
    hit = 1'b0;
    for (int i = 0; i < NUM_RATES - 1; i++) begin
      if (!hit && (v < rate_at(i) + (rate_at(i + 1) - rate_at(i)) / 2)) begin
        r   = rate_at(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [GAIN_W-1:0] scale5(input logic [4:0] f);
    logic [15:0] p;
    p = (16'(f) * 16'd255) / 16'd31;
    return p[GAIN_W-1:0];
  endfunction

  function automatic logic [GAIN_W-1:0] combine(input logic [4:0] m, input logic [4:0] p);
    logic [15:0] prod;
    prod = (16'(8'd255 - scale5(m)) * 16'(8'd255 - scale5(p))) / 16'd255;
    return prod[GAIN_W-1:0];
  endfunction

endpackage

// File: rtl/ac97_cmd_port.sv
module ac97_cmd_port
  import ac97_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [CMD_W-1:0]  cmd_word
);
  localparam logic [CMD_W-1:0] WR_KEEP = 32'hC0FF_FFFF;
  localparam int               DV_BIT  = 25;

  ac_cmd_t cmd;
  logic    rdy_q;
  logic    take;
  logic    primary;

  assign cmd       = ac_cmd_t'(cmd_data);
  assign cmd_ready = rdy_q;
  assign take      = cmd_valid && rdy_q;
  assign primary   = (cmd.sel == 2'b00);
  assign wr_en     = take && primary && !cmd.rd;
  assign acc_addr  = cmd.addr;
  assign wr_data   = cmd.data;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
    end else if (take && primary) begin
      if (cmd.rd) begin
        cmd_word         <= {cmd.sel, 6'b0, cmd.rd, cmd.addr, rd_data};
        cmd_word[DV_BIT] <= 1'b1;
      end else begin
        cmd_word <= cmd_data & WR_KEEP;
      end
    end
  end

  p_sel_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data[31:30] != 2'b00) |=> (cmd_word == $past(cmd_word)));

  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data[31:30] == 2'b00 && cmd_data[23])
      |=> (cmd_word[25] && cmd_word[23] && cmd_word[22:16] == $past(cmd_data[22:16])));

  p_ready_after_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmd_ready);

endmodule

// File: rtl/ac97_reg_bank.sv
module ac97_reg_bank
  import ac97_regs_pkg::*;
#(
  parameter int ENTRIES = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] main_vol,
  output logic [DATA_W-1:0] pcm_vol
);
  localparam logic [IDX_W-1:0] I_MAIN = idx_of(REG_MAIN_VOL);
  localparam logic [IDX_W-1:0] I_PCM  = idx_of(REG_PCM_VOL);
  localparam logic [IDX_W-1:0] I_PWR  = idx_of(REG_PWR);
  localparam logic [IDX_W-1:0] I_XCTL = idx_of(REG_XCTL);
  localparam logic [IDX_W-1:0] I_DAC  = idx_of(REG_DAC_RATE);
  localparam logic [IDX_W-1:0] I_ADC  = idx_of(REG_ADC_RATE);
  localparam logic [IDX_W-1:0] I_XID  = idx_of(REG_XID);

  logic [DATA_W-1:0] bank [ENTRIES];
  logic [IDX_W-1:0]  idx;
  logic              soft_rst;
  logic              vra_on;
  logic [DATA_W-1:0] main_sat;

  assign idx      = idx_of(addr);
  assign soft_rst = wr_en && (addr == REG_SOFTRST);
  assign vra_on   = bank[I_XCTL][0];
  assign rd_data  = bank[idx];
  assign main_vol = bank[I_MAIN];
  assign pcm_vol  = bank[I_PCM];

  always_comb begin
    main_sat = wr_data;
    if (wr_data[13]) main_sat[12:8] = 5'h1F;
    if (wr_data[5])  main_sat[4:0]  = 5'h1F;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      for (int i = 0; i < ENTRIES; i++) bank[i] <= reset_value(IDX_W'(i));
    end else if (wr_en) begin
      case (addr)
        REG_MAIN_VOL: bank[I_MAIN] <= main_sat & VOL_KEEP;
        REG_PCM_VOL:  bank[I_PCM]  <= wr_data & VOL_KEEP;
        REG_XCTL: begin
          bank[I_XCTL] <= {bank[I_XCTL][DATA_W-1:1], wr_data[0]};
          if (!wr_data[0]) begin
            bank[I_DAC] <= RATE_MAX;
            bank[I_ADC] <= RATE_MAX;
          end
        end
        REG_DAC_RATE, REG_ADC_RATE: begin
          if (vra_on) bank[idx] <= snap_rate(wr_data);
        end
        REG_PWR:  bank[I_PWR] <= {wr_data[15:8], bank[I_PWR][7:0]};
        REG_XID, REG_ID_HI, REG_ID_LO: ;
        default:  bank[idx] <= wr_data;
      endcase
    end
  end

  p_main_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_MAIN_VOL) |=> ((bank[I_MAIN] & 16'h60E0) == 16'h0000));

  p_rate_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DAC_RATE && !bank[I_XCTL][0]) |=> (bank[I_DAC] == $past(bank[I_DAC])));

  p_xid_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_XID) |=> (bank[I_XID] == $past(bank[I_XID])));

  p_vra_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_XCTL && !wr_data[0]) |=> (bank[I_ADC] == RATE_MAX && bank[I_DAC] == RATE_MAX));

endmodule

// File: rtl/ac97_out_level.sv
module ac97_out_level
  import ac97_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] main_vol,
  input  logic [DATA_W-1:0] pcm_vol,
  output logic [GAIN_W-1:0] gain_left,
  output logic [GAIN_W-1:0] gain_right,
  output logic              mute
);
  localparam int CH = 2;

  logic [GAIN_W-1:0] lvl [CH];

  for (genvar c = 0; c < CH; c++) begin : g_chan
    localparam int LSB = (c == 0) ? 8 : 0;
    assign lvl[c] = combine(main_vol[LSB +: 5], pcm_vol[LSB +: 5]);
  end

  assign gain_left  = lvl[0];
  assign gain_right = lvl[1];
  assign mute       = main_vol[15] | pcm_vol[15];

  p_unity_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (main_vol[12:8] == 5'd0 && pcm_vol[12:8] == 5'd0) |-> (gain_left == 8'd255));

  p_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (main_vol[4:0] == 5'h1F) |-> (gain_right == 8'd0));

endmodule

// File: rtl/ac97_codec_regs.sv
module ac97_codec_regs
  import ac97_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [CMD_W-1:0]  cmd_word,
  output logic [GAIN_W-1:0] gain_left,
  output logic [GAIN_W-1:0] gain_right,
  output logic              mute
);
  logic              wr_en;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] main_vol;
  logic [DATA_W-1:0] pcm_vol;

  ac97_cmd_port u_port (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rd_data(rd_data), .wr_en(wr_en), .acc_addr(acc_addr), .wr_data(wr_data),
    .cmd_word(cmd_word)
  );

  ac97_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data),
    .main_vol(main_vol), .pcm_vol(pcm_vol)
  );

  ac97_out_level u_level (
    .clk(clk), .rst_n(rst_n),
    .main_vol(main_vol), .pcm_vol(pcm_vol),
    .gain_left(gain_left), .gain_right(gain_right), .mute(mute)
  );

endmodule

// File: tb/sim_ac97_codec_regs.sv
module sim_ac97_codec_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic [31:0] cmd_word;
  logic [7:0]  gain_left, gain_right;
  logic        mute;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ac97_codec_regs u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_word(cmd_word),
    .gain_left(gain_left), .gain_right(gain_right), .mute(mute)
  );

  localparam int NV = 39;
  // {requirement, command, expected response}
  localparam logic [71:0] VEC [NV] = '{
    {8'd4,  32'h0080_0000, 32'h0280_6A90},  // R4 reset register
    {8'd4,  32'h0098_0000, 32'h0298_8808},  // R4 PCM volume default
    {8'd4,  32'h00A6_0000, 32'h02A6_000F},  // R4 power-down default
    {8'd3,  32'h0002_2020, 32'h0002_2020},  // R3 write echo
    {8'd5,  32'h0082_0000, 32'h0282_1F1F},  // R5 saturation
    {8'd5,  32'h0018_FFFF, 32'h0018_FFFF},
    {8'd5,  32'h0098_0000, 32'h0298_9F1F},  // R5 PCM mask
    {8'd3,  32'h3F20_1234, 32'h0020_1234},  // R3 bits 29:24 dropped
    {8'd10, 32'h00A0_0000, 32'h02A0_1234},  // R10 raw store
    {8'd7,  32'h002C_1F40, 32'h002C_1F40},
    {8'd7,  32'h00AC_0000, 32'h02AC_BB80},  // R7 locked at 48000
    {8'd6,  32'h002A_FFFF, 32'h002A_FFFF},
    {8'd6,  32'h00AA_0000, 32'h02AA_0401},  // R6 only bit 0
    {8'd7,  32'h002C_2527, 32'h002C_2527},
    {8'd7,  32'h00AC_0000, 32'h02AC_1F40},  // R7 9511 -> 8000
    {8'd7,  32'h002C_2528, 32'h002C_2528},
    {8'd7,  32'h00AC_0000, 32'h02AC_2B11},  // R7 9512 -> 11025
    {8'd7,  32'h0032_B3E1, 32'h0032_B3E1},
    {8'd7,  32'h00B2_0000, 32'h02B2_AC44},  // R7 46049 -> 44100
    {8'd7,  32'h0032_B3E2, 32'h0032_B3E2},
    {8'd7,  32'h00B2_0000, 32'h02B2_BB80},  // R7 46050 -> 48000
    {8'd7,  32'h0032_7530, 32'h0032_7530},
    {8'd7,  32'h00B2_0000, 32'h02B2_7D00},  // R7 30000 -> 32000
    {8'd6,  32'h002A_0000, 32'h002A_0000},
    {8'd6,  32'h00B2_0000, 32'h02B2_BB80},  // R6 rate restored
    {8'd6,  32'h00AA_0000, 32'h02AA_0400},
    {8'd8,  32'h0026_1234, 32'h0026_1234},
    {8'd8,  32'h00A6_0000, 32'h02A6_120F},  // R8 low byte kept
    {8'd9,  32'h0028_FFFF, 32'h0028_FFFF},
    {8'd9,  32'h00A8_0000, 32'h02A8_0A05},  // R9 ext id
    {8'd9,  32'h007E_BEEF, 32'h007E_BEEF},
    {8'd9,  32'h00FE_0000, 32'h02FE_0000},  // R9 id word
    {8'd1,  32'h4080_0000, 32'h02FE_0000},  // R1 select 1 read dropped
    {8'd1,  32'h8002_FFFF, 32'h02FE_0000},  // R1 select 2 write dropped
    {8'd1,  32'h0082_0000, 32'h0282_1F1F},  // R1 main volume untouched
    {8'd4,  32'h0000_5555, 32'h0000_5555},  // R4 soft reset
    {8'd4,  32'h0082_0000, 32'h0282_8000},
    {8'd4,  32'h00A0_0000, 32'h02A0_0000},
    {8'd4,  32'h00AC_0000, 32'h02AC_BB80}
  };

  function automatic int lvl(input int m, input int p);
    return ((255 - (255 * m) / 31) * (255 - (255 * p) / 31)) / 255;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", {31'd0, cmd_ready}, 32'd0);     // R12 not ready in reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12", {31'd0, cmd_ready}, 32'd1);     // R12 ready
    check("R4", cmd_word, 32'd0);                // R4 response cleared
    check("R11", {31'd0, mute}, 32'd1);          // R11 reset mute
    check("R11", {24'd0, gain_left}, 32'(lvl(0, 8)));
    check("R11", {24'd0, gain_right}, 32'(lvl(0, 8)));

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][63:32]);
      check($sformatf("R%0d", VEC[i][71:64]), cmd_word, VEC[i][31:0]);
    end

    // R11: asymmetric levels
    send(32'h0002_0A05);
    send(32'h0018_0003);
    check("R11", {24'd0, gain_left}, 32'(lvl(10, 0)));
    check("R11", {24'd0, gain_right}, 32'(lvl(5, 3)));
    check("R11", {31'd0, mute}, 32'd0);
    send(32'h0018_8003);
    check("R11", {31'd0, mute}, 32'd1);
    send(32'h0018_1F1F);
    check("R11", {24'd0, gain_left}, 32'd0);

    // R12: data without valid is not taken
    @(negedge clk);
    cmd_data = 32'h0002_FFFF;
    @(negedge clk);
    send(32'h0082_0000);
    check("R12", cmd_word, 32'h0282_0A05);

    // R4: hardware reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send(32'h0082_0000);
    check("R4", cmd_word, 32'h0282_8000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule